// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models the slave side of a byte-organised serial EEPROM on a two-wire bus. It runs on a fast system clock, oversamples the bus clock and data lines, finds start and stop conditions, and decodes a device address byte. That byte is checked against a fixed device-type nibble and three strap inputs. A matched write transfer takes a two-byte word address and then collects data bytes into a page buffer. A matched read transfer streams bytes from the current address for as long as the bus master keeps acknowledging.

Page data goes into the storage array only when a stop condition ends the transfer. A busy window follows the commit, and during it the device does not answer its address. The master can therefore poll for completion by sending the address until it sees an acknowledge. A write-protect input blocks writes to the top quarter of the array. The address width is a parameter. The default of 10 bits keeps the register array small, and a full 8192-byte part uses `ADDR_W = 13`. The slave drives SDA only through an open-drain enable: when `sda_oe` is 1, the pad pulls the line low.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After a start condition, the first byte is the device address. It is accepted only when bits 7..4 equal 4'b1010 and bits 3..1 equal `strap_i[2:1:0]`. A byte that does not match gets no acknowledge, and the slave ignores the bus until the next start.
- R2: Bit 0 of the device address sets the direction. A value of 1 starts a read from the current address, and 0 starts a write.
- R3: The slave acknowledges by holding `sda_oe` at 1 through the ninth clock. It does this for a matched device address, for both word address bytes of a write, and for every data byte written.
- R4: A write sends the word address as two bytes, high byte first. The low `ADDR_W` bits of the 16-bit value set the current address.
- R5: During a page write, each data byte goes to the current address. The low 5 address bits then increment and wrap inside the same 32-byte page, and the upper bits stay fixed. A transfer may write fewer than 32 bytes. When more than 32 bytes are sent, the later bytes overwrite the earlier ones.
- R6: Written bytes do not reach the array until a stop condition. A read issued before the stop returns the old contents. After the stop, the commit and a further `BUSY_CYCLES` clocks form a busy window, and the device address is not acknowledged during it.
- R7: While `wp_i` is 1, bytes addressed to the top quarter of the array (upper two address bits 2'b11) are acknowledged but discarded. Writes elsewhere, and all writes while `wp_i` is 0, take effect.
- R8: SDA is sampled on the rising edge of SCL. The slave changes `sda_oe` only after a falling edge of SCL, or after a start or stop condition.
- R9: A read returns the byte at the current address and then increments the address, wrapping from the last address to 0. Reading continues while the master acknowledges. After a master not-acknowledge, the slave releases SDA.
- R10: A stop condition ends any transfer and releases SDA. A repeated start begins a new device address phase and keeps the current address, so a read can follow an address-setting write.
- R11: After reset, `sda_oe` is 0 and the slave waits for a start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| strap_i | input | 3 | Device address select straps |
| wp_i | input | 1 | Write protect for the top quarter of the array |

## Verification
The assertions assume a well-formed master. SDA changes only while SCL is low, except for a start or stop. Every SCL level is held for several system clocks, so that the synchroniser and the edge detector see each edge exactly once. They also assume that `wp_i` is stable during a commit. The bench drives SCL and SDA from tasks with a fixed quarter-bit spacing of several clocks and changes SDA only in the low phase, apart from start and stop. It changes the strap and protect inputs only between transfers while the bus is idle, and it leaves the busy window long enough to pass before it checks the committed data.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } ee_state_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam logic [3:0] BIT_ACK  = 4'd8;
  localparam logic [3:0] BIT_DONE = 4'd9;

endpackage

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sync;
  logic [SYNC_STAGES-1:0] sda_sync;
  logic scl_prev;
  logic sda_prev;
  logic scl_s;
  logic sda_s;

  assign scl_s = scl_sync[SYNC_STAGES-1];
  assign sda_s = sda_sync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign sda_o     = sda_s;
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/eeprom_page_buffer.sv
module eeprom_page_buffer #(
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [PAGE_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PAGE_W-1:0] ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              any_valid
);

  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] slot [SLOTS];
  logic [SLOTS-1:0]  valid;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        valid[g] <= 1'b0;
      end else if (we && widx == PAGE_W'(g)) begin
        valid[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (we && widx == PAGE_W'(g)) begin
        slot[g] <= wdata;
      end
    end
  end

  assign rdata     = slot[ridx];
  assign rvalid    = valid[ridx];
  assign any_valid = |valid;

endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 5,
  parameter int BUSY_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);

  localparam int BYTE_W = 8;
  localparam int HI_W   = ADDR_W - BYTE_W;
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  ee_state_t         state;
  logic [3:0]        bcnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic [HI_W-1:0]   ah_q;
  logic [ADDR_W-1:0] ptr;
  logic [PG_W-1:0]   page_q;
  logic              mack;
  logic              oe_q;
  logic              commit_act;
  logic [PAGE_W-1:0] cidx;
  logic [BUSY_W-1:0] busy_cnt;
  logic [BYTE_W-1:0] pb_rdata, mem_rdata;
  logic              pb_rvalid, pb_any;
  logic              busy, byte_end, ack_end, dev_ok, commit_last, prot;
  logic              pb_we, pb_clr, mem_we;
  logic [ADDR_W-1:0] mem_waddr;

  i2c_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_o(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eeprom_page_buffer #(.PAGE_W(PAGE_W), .DATA_W(BYTE_W)) u_pbuf (
    .clk(clk), .rst(rst), .clr(pb_clr), .we(pb_we),
    .widx(ptr[PAGE_W-1:0]), .wdata(sh), .ridx(cidx),
    .rdata(pb_rdata), .rvalid(pb_rvalid), .any_valid(pb_any)
  );

  eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(pb_rdata),
    .raddr(ptr), .rdata(mem_rdata)
  );

  assign busy        = commit_act | (busy_cnt != '0);
  assign byte_end    = scl_fall && (bcnt == BIT_ACK);
  assign ack_end     = scl_fall && (bcnt == BIT_DONE);
  assign dev_ok      = (sh[7:4] == DEV_TYPE) && (sh[3:1] == strap_i) && !busy;
  assign commit_last = commit_act && (cidx == '1);
  assign pb_we       = byte_end && (state == ST_WDAT);
  assign pb_clr      = (byte_end && (state == ST_ALO)) || commit_last;
  assign mem_waddr   = {page_q, cidx};
  assign prot        = wp_i && (&mem_waddr[ADDR_W-1:ADDR_W-2]);
  assign mem_we      = commit_act && pb_rvalid && !prot;
  assign sda_oe      = oe_q;

  // Bus-side control: address phases, page collection, read streaming.
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bcnt   <= '0;
      sh     <= '0;
      tx     <= '0;
      ah_q   <= '0;
      ptr    <= '0;
      page_q <= '0;
      mack   <= 1'b0;
      oe_q   <= 1'b0;
    end else if (start_det) begin
      state <= ST_DEV;
      bcnt  <= '0;
      oe_q  <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE;
      bcnt  <= '0;
      oe_q  <= 1'b0;
    end else if (scl_rise && state != ST_IDLE) begin
      if (state == ST_RDAT) begin
        if (bcnt < BIT_ACK) begin
          bcnt <= bcnt + 4'd1;
        end else if (bcnt == BIT_ACK) begin
          mack <= ~sda_s;
          bcnt <= BIT_DONE;
        end
      end else if (bcnt < BIT_ACK) begin
        sh   <= {sh[6:0], sda_s};
        bcnt <= bcnt + 4'd1;
      end
    end else if (scl_fall) begin
      unique case (state)
        ST_DEV: begin
          if (byte_end) begin
            if (dev_ok) begin
              oe_q <= 1'b1;
              bcnt <= BIT_DONE;
              mack <= 1'b1;
              state <= sh[0] ? ST_RDAT : ST_AHI;
            end else begin
              state <= ST_IDLE;
              bcnt  <= '0;
            end
          end
        end
        ST_AHI, ST_ALO, ST_WDAT: begin
          if (byte_end) begin
            oe_q <= 1'b1;
            bcnt <= BIT_DONE;
            if (state == ST_AHI) begin
              ah_q  <= sh[HI_W-1:0];
              state <= ST_ALO;
            end else if (state == ST_ALO) begin
              ptr    <= {ah_q, sh};
              page_q <= {ah_q, sh[7:PAGE_W]};
              state  <= ST_WDAT;
            end else begin
              ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
            end
          end else if (ack_end) begin
            oe_q <= 1'b0;
            bcnt <= '0;
          end
        end
        ST_RDAT: begin
          if (bcnt >= 4'd1 && bcnt < BIT_ACK) begin
            tx   <= {tx[6:0], tx[7]};
            oe_q <= ~tx[6];
          end else if (bcnt == BIT_ACK) begin
            oe_q <= 1'b0;
          end else if (bcnt == BIT_DONE) begin
            if (mack) begin
              tx   <= mem_rdata;
              oe_q <= ~mem_rdata[7];
              ptr  <= ptr + 1'b1;
              bcnt <= '0;
            end else begin
              oe_q  <= 1'b0;
              bcnt  <= '0;
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // Array-side control: commit buffered page after stop, then busy window.
  always_ff @(posedge clk) begin
    if (rst) begin
      commit_act <= 1'b0;
      cidx       <= '0;
      busy_cnt   <= '0;
    end else if (commit_act) begin
      cidx <= cidx + 1'b1;
      if (commit_last) begin
        commit_act <= 1'b0;
        busy_cnt   <= BUSY_W'(BUSY_CYCLES);
      end
    end else if (stop_det && pb_any && !busy) begin
      commit_act <= 1'b1;
      cidx       <= '0;
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/eeprom_slave_checker.sv
module eeprom_slave_checker #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic              wp_i,
  input logic              pb_we,
  input logic [ADDR_W-1:0] ptr,
  input logic              commit_act
);

  // R10: any stop leaves the line released on the next cycle.
  assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R8: the output enable moves only after an SCL fall, start or stop.
  assert_drive_after_fall_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  // R7: no array write lands in the protected quarter while protected.
  assert_no_protected_write_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !(wp_i && (&mem_waddr[ADDR_W-1:ADDR_W-2])));

  // R5: collecting a page byte never moves the page bits of the pointer.
  assert_page_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    pb_we |=> $stable(ptr[ADDR_W-1:PAGE_W]));

  // R6: a commit begins only in response to a stop condition.
  assert_commit_after_stop_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(commit_act) |-> $past(stop_det));

endmodule

bind i2c_eeprom_slave eeprom_slave_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .mem_we(mem_we),
  .mem_waddr(mem_waddr), .wp_i(wp_i), .pb_we(pb_we), .ptr(ptr),
  .commit_act(commit_act)
);

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;

  localparam int AW    = 10;
  localparam int PW    = 5;
  localparam int BUSY  = 2000;
  localparam int Q     = 5;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic sda_oe;
  logic [2:0] strap = 3'd5;
  logic wp = 1'b0;
  logic sda_line;

  always #5 clk = ~clk;
  assign sda_line = msda & ~sda_oe;

  i2c_eeprom_slave #(.ADDR_W(AW), .PAGE_W(PW), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .wp_i(wp)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_mem [DEPTH];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; wclk(Q);
    scl = 1'b1;  wclk(Q);
    msda = 1'b0; wclk(Q);
    scl = 1'b0;  wclk(Q);
  endtask

  task automatic bus_stop();
    msda = 1'b0; wclk(Q);
    scl = 1'b1;  wclk(Q);
    msda = 1'b1; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; wclk(Q);
      scl = 1'b1;  wclk(2*Q);
      scl = 1'b0;  wclk(Q);
    end
    msda = 1'b1; wclk(Q);
    scl = 1'b1;  wclk(Q);
    ack = ~sda_line;
    wclk(Q);
    scl = 1'b0;  wclk(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      msda = 1'b1; wclk(Q);
      scl = 1'b1;  wclk(Q);
      b = {b[6:0], sda_line};
      wclk(Q);
      scl = 1'b0;  wclk(Q);
    end
    msda = give_ack ? 1'b0 : 1'b1; wclk(Q);
    scl = 1'b1; wclk(2*Q);
    scl = 1'b0; wclk(Q);
    msda = 1'b1;
  endtask

  function automatic logic [7:0] dev_byte(input logic [2:0] s, input bit rd);
    return {4'b1010, s, rd};
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed + i * 29) & 255);
  endfunction

  task automatic model_write(input int wa, input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      int a;
      a = (wa & ~31) | ((wa + i) & 31);
      if (!(wp && a >= (3 * DEPTH) / 4)) exp_mem[a] = pat(seed, i);
    end
  endtask

  task automatic write_body(input int wa, input int n, input int seed, input string tag);
    bit ack;
    send_byte(dev_byte(strap, 1'b0), ack);
    chk(ack, "R3 device address ack", ack, 1);
    send_byte(8'((wa >> 8) & 255), ack);
    chk(ack, "R3/R4 high address ack", ack, 1);
    send_byte(8'(wa & 255), ack);
    chk(ack, "R3/R4 low address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(pat(seed, i), ack);
      chk(ack, tag, ack, 1);
    end
  endtask

  task automatic ee_write(input int wa, input int n, input int seed, input string tag);
    bus_start();
    write_body(wa, n, seed, tag);
    bus_stop();
    model_write(wa, n, seed);
    wclk(BUSY + 200);
  endtask

  task automatic ee_read(input int wa, input int n, input string tag);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(dev_byte(strap, 1'b0), ack);
    send_byte(8'((wa >> 8) & 255), ack);
    send_byte(8'(wa & 255), ack);
    bus_start();
    send_byte(dev_byte(strap, 1'b1), ack);
    chk(ack, "R2 read device address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i != n - 1);
      chk(b == exp_mem[(wa + i) % DEPTH], tag, b, exp_mem[(wa + i) % DEPTH]);
    end
    wclk(Q);
    chk(sda_oe == 1'b0, "R9 release after master nack", sda_oe, 0);
    bus_stop();
    wclk(2);
    chk(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    wclk(5);
    rst = 1'b0;
    wclk(5);
    chk(sda_oe == 1'b0, "R11 reset released", sda_oe, 0);

    // R1: sweep every 7-bit address with strap fixed at 5
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte(8'(a << 1), ack);
      bus_stop();
      chk(ack == (a == {4'b1010, 3'd5}), "R1 address sweep", ack, (a == {4'b1010, 3'd5}));
    end

    // R1: each strap value matches only itself
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      bus_start(); send_byte(dev_byte(3'(s), 1'b0), ack); bus_stop();
      chk(ack, "R1 strap match", ack, 1);
      bus_start(); send_byte(dev_byte(3'(s ^ 3), 1'b0), ack); bus_stop();
      chk(!ack, "R1 strap mismatch", ack, 0);
    end
    strap = 3'd5;

    // R4/R5: full page, partial page, wrapping page
    ee_write(12'h040, 32, 3, "R3 full page data ack");
    ee_read(12'h040, 32, "R4/R8 full page readback");
    ee_write(12'h0A3, 5, 17, "R3 partial page data ack");
    ee_read(12'h0A3, 5, "R5 partial page readback");
    ee_write(12'h11E, 34, 7, "R5 wrap data ack");
    ee_read(12'h100, 32, "R5 page wrap readback");

    // R6: data not visible before stop, busy nack after stop
    bus_start();
    write_body(12'h040, 32, 11, "R3 pending page ack");
    bus_start();
    send_byte(dev_byte(strap, 1'b1), ack);
    recv_byte(b, 1'b0);
    chk(b == exp_mem[12'h040], "R6 old data before stop", b, exp_mem[12'h040]);
    bus_stop();
    model_write(12'h040, 32, 11);
    bus_start(); send_byte(dev_byte(strap, 1'b0), ack); bus_stop();
    chk(!ack, "R6 busy nack", ack, 0);
    wclk(BUSY + 200);
    bus_start(); send_byte(dev_byte(strap, 1'b0), ack); bus_stop();
    chk(ack, "R6 ack after busy", ack, 1);
    ee_read(12'h040, 32, "R6 committed page");

    // R7: write protection of the top quarter
    ee_write(12'h3F0, 16, 20, "R7 seed protected region ack");
    wp = 1'b1;
    ee_write(12'h3F0, 4, 50, "R7 protected bytes still acked");
    ee_read(12'h3F0, 4, "R7 protected bytes unchanged");
    ee_write(12'h2F0, 4, 60, "R7 unprotected ack");
    ee_read(12'h2F0, 4, "R7 unprotected written");
    wp = 1'b0;
    ee_write(12'h3F0, 4, 70, "R7 unprotected when low ack");
    ee_read(12'h3F0, 8, "R7 written when protect low");

    // R9: sequential read rolls over from last address to zero
    ee_write(DEPTH - 1, 1, 90, "R9 last address ack");
    ee_write(0, 1, 91, "R9 first address ack");
    ee_read(DEPTH - 1, 2, "R9 read rollover");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule